// File: doc/BRIEF.md
# Serial Port with Prioritised Interrupt Requests

This block is a full-duplex asynchronous serial port. Its transmitter turns one character of 7 or 8 data bits into a frame on a single line. The frame has a low start bit, the data least-significant bit first, an optional parity bit and one high stop bit. Its receiver rebuilds characters from the incoming line, which it oversamples with a baud tick that the surrounding logic supplies. Each bit lasts sixteen ticks.

The block raises three kinds of single-cycle request: transmit-done, receive-done and receive-error. A receive error is any one of a parity mismatch, a low stop bit or an overrun, and each of these three conditions sets its own sticky flag. A routing input picks the request that a faulty character raises: the error request, or the ordinary receive-done request. All three requests are latched as pending. A fixed-priority encoder reports the most urgent pending request as a 2-bit code, and an acknowledge strobe retires the request being reported.

Top module: `sio_irq_uart`

## Requirements
- R1: The transmitter accepts `tx_start` only while `tx_en` is high and `tx_busy` is low. The frame then begins on the next clock edge with a low start bit. The data follows least-significant bit first (7 bits when `cfg_len8`=0, 8 bits when 1), then the parity bit if enabled, then one high stop bit. Every bit lasts 16 baud ticks, and `txd` rests high while idle.
- R2: `irq_tx_done` is high for exactly one cycle once per frame, after the stop bit has been sent in full.
- R3: A low level that is still low 8 ticks later starts a receive frame. Each later bit is sampled at its middle. The received character appears on `rx_data` (bit 7 reads 0 in 7-bit mode) and `rx_full` is set. `rx_read` clears `rx_full`.
- R4: `cfg_parity` selects the parity mode: 0 = none, 1 = even, 2 = odd, 3 = none. Even parity makes the count of ones over the data bits and the parity bit even. Odd parity makes that count odd.
- R5: The flags `err_parity`, `err_frame` (stop bit sampled low) and `err_overrun` (a character completes while `rx_full` is set and `rx_read` is low) are sticky. `err_clear` clears them, but a flag being set in the same cycle stays set.
- R6: A character with no error raises only `irq_rx_done`. A character with any error raises only `irq_rx_err` when `cfg_err_route`=1, and only `irq_rx_done` when `cfg_err_route`=0. The two receive requests never occur together.
- R7: While `rx_en` is low the receiver raises neither receive request, and it neither loads `rx_data` nor sets `rx_full`.
- R8: Each request pulse sets a pending bit. `irq_code` reports 3 when a receive error is pending, otherwise 2 when a receive-done is pending, otherwise 1 when a transmit-done is pending, and 0 when nothing is pending.
- R9: `irq_ack` clears only the pending bit that `irq_code` reports in that cycle. A request pulse in the same cycle is still latched.
- R10: After reset, `txd` is high, `tx_busy`, `rx_full`, all flags and all request pulses are low, and `irq_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_parity | input | 2 | Parity mode (0 none, 1 even, 2 odd, 3 none) |
| cfg_err_route | input | 1 | 1 = faulty character raises error request |
| tx_data | input | 8 | Character to send |
| tx_start | input | 1 | Send strobe |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_read | input | 1 | Receive buffer has been read |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | Receive buffer holds unread data |
| err_clear | input | 1 | Clears the sticky error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| irq_rx_err | output | 1 | Receive-error request pulse |
| irq_rx_done | output | 1 | Receive-done request pulse |
| irq_tx_done | output | 1 | Transmit-done request pulse |
| irq_ack | input | 1 | Retire the reported request |
| irq_code | output | 2 | Highest pending request code |

## Verification
The acknowledge of a pending request and the arrival of a new receive-done pulse can land in the same cycle. The bench provokes this by leaving a transmit-done pending and then receiving a clean character. It watches for the receive-done pulse and raises `irq_ack` in exactly that cycle. The code must then read 2: the transmit-done has retired and the new request is held. A second pass repeats the collision while receive-done itself is the request being reported, and the code must stay at 2 because the set wins over the clear.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int CHAR_W  = 8;
  localparam int FRAME_W = 11;

  // request index order inside the pending vector
  localparam int REQ_TX  = 0;
  localparam int REQ_RXD = 1;
  localparam int REQ_RXE = 2;
  localparam int REQ_N   = 3;

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == 2'd1) || (mode == 2'd2);
  endfunction

  // parity bit to append for the selected mode
  function automatic logic parity_bit(input logic [CHAR_W-1:0] d,
                                      input logic len8,
                                      input logic [1:0] mode);
    logic x;
    x = (^d[CHAR_W-2:0]) ^ (len8 & d[CHAR_W-1]);
    return (mode == 2'd2) ? ~x : x;
  endfunction

  function automatic logic [3:0] frame_len(input logic len8,
                                           input logic [1:0] mode);
    return 4'd9 + {3'b000, len8} + {3'b000, parity_on(mode)};
  endfunction

  // frame as sent, bit 0 first; unused upper bits stay high
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [CHAR_W-1:0] d,
                                                    input logic len8,
                                                    input logic [1:0] mode);
    logic [FRAME_W-1:0] v;
    int pos;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < CHAR_W - 1; i++) v[1+i] = d[i];
    if (len8) v[CHAR_W] = d[CHAR_W-1];
    pos = len8 ? CHAR_W + 1 : CHAR_W;
    if (parity_on(mode)) v[pos] = parity_bit(d, len8, mode);
    return v;
  endfunction

  function automatic logic [1:0] prio_code(input logic [REQ_N-1:0] p);
    if (p[REQ_RXE]) return 2'd3;
    if (p[REQ_RXD]) return 2'd2;
    if (p[REQ_TX])  return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/sio_irq_tx.sv
module sio_irq_tx
  import sio_irq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              len8,
  input  logic [1:0]        mode,
  input  logic [CHAR_W-1:0] data,
  input  logic              start,
  output logic              busy,
  output logic              txd,
  output logic              done
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;
  logic [CW-1:0]      cnt;
  logic               busy_q;
  logic               done_q;

  logic accept, bit_end, last_bit;
  assign accept   = start && en && !busy_q;
  assign bit_end  = busy_q && tick && (cnt == CNT_LAST);
  assign last_bit = bit_end && (left == 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      left   <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_bit;
      if (accept) begin
        shreg  <= frame_bits(data, len8, mode);
        left   <= frame_len(len8, mode);
        cnt    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && tick) begin
        if (cnt == CNT_LAST) begin
          cnt   <= '0;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - 4'd1;
          if (left == 4'd1) busy_q <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? shreg[0] : 1'b1;
  assign done = done_q;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd); // R1
  AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q || $rose(busy_q)); // R2

endmodule

// File: rtl/sio_irq_rx.sv
module sio_irq_rx
  import sio_irq_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              len8,
  input  logic [1:0]        mode,
  input  logic              route_err,
  input  logic              rxd,
  input  logic              rd,
  input  logic              clr,
  output logic [CHAR_W-1:0] data,
  output logic              full,
  output logic              err_par,
  output logic              err_frm,
  output logic              err_ovr,
  output logic              irq_err,
  output logic              irq_done
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} rx_st_e;

  logic [SYNC-1:0]   sync;
  logic              rxs;
  rx_st_e            st;
  logic [CW-1:0]     cnt;
  logic [2:0]        bidx;
  logic [CHAR_W-1:0] shreg;
  logic              pbit;
  logic [CHAR_W-1:0] data_q;
  logic              full_q;
  logic [2:0]        flags;
  logic              irq_err_q, irq_done_q;

  // named internal events for the checks
  logic complete, stop_bad, par_bad, ovr_hit, any_err;
  logic [2:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC-2:0], rxd};
  end
  assign rxs = sync[SYNC-1];

  assign last_idx = len8 ? 3'd7 : 3'd6;
  assign complete = (st == S_STOP) && tick && (cnt == CNT_LAST);
  assign stop_bad = !rxs;
  assign par_bad  = parity_on(mode) && (pbit != parity_bit(shreg, len8, mode));
  assign ovr_hit  = full_q && !rd;
  assign any_err  = stop_bad || par_bad || ovr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (tick && !rxs) begin
          st    <= S_START;
          cnt   <= '0;
          shreg <= '0;
        end
        S_START: if (tick) begin
          if (cnt == CNT_MID) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxs ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt         <= '0;
            shreg[bidx] <= rxs;
            if (bidx == last_idx) st <= parity_on(mode) ? S_PAR : S_STOP;
            else                  bidx <= bidx + 3'd1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt  <= '0;
            pbit <= rxs;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            st  <= rxs ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: if (rxs) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      full_q     <= 1'b0;
      flags      <= '0;
      irq_err_q  <= 1'b0;
      irq_done_q <= 1'b0;
    end else begin
      irq_err_q  <= complete && en && any_err && route_err;
      irq_done_q <= complete && en && !(any_err && route_err);
      if (complete && en) begin
        data_q <= shreg;
        full_q <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
      flags <= (clr ? 3'b000 : flags) |
               ((complete && en) ? {ovr_hit, stop_bad, par_bad} : 3'b000);
    end
  end

  assign data     = data_q;
  assign full     = full_q;
  assign err_par  = flags[0];
  assign err_frm  = flags[1];
  assign err_ovr  = flags[2];
  assign irq_err  = irq_err_q;
  assign irq_done = irq_done_q;

  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_err_q && irq_done_q)); // R6
  AST_RX_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_err_q && !irq_done_q); // R7
  AST_RX_ERR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && en && any_err && !route_err) |=> irq_done_q); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr) |=> flags[0]); // R5
  AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done_q |-> full_q); // R3

endmodule

// File: rtl/sio_irq_arb.sv
module sio_irq_arb
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] req,
  input  logic             ack,
  output logic [1:0]       code
);
  logic [REQ_N-1:0] pend;
  logic [REQ_N-1:0] retire;

  assign code = prio_code(pend);

  for (genvar g = 0; g < REQ_N; g++) begin : g_pend
    assign retire[g] = ack && (code == 2'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= req[g] | (pend[g] & ~retire[g]);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req[REQ_RXD] |=> code >= 2'd2); // R9
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req[REQ_RXE] |=> code == 2'd3); // R8
  AST_ACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && code == 2'd1 && req == '0) |=> code == 2'd0); // R9

endmodule

// File: rtl/sio_irq_uart.sv
module sio_irq_uart
  import sio_irq_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       cfg_len8,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_err_route,
  input  logic [7:0] tx_data,
  input  logic       tx_start,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_read,
  output logic [7:0] rx_data,
  output logic       rx_full,
  input  logic       err_clear,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       irq_rx_err,
  output logic       irq_rx_done,
  output logic       irq_tx_done,
  input  logic       irq_ack,
  output logic [1:0] irq_code
);
  logic tx_done_w, rx_err_w, rx_done_w;
  logic [REQ_N-1:0] req_w;

  sio_irq_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_en),
    .len8(cfg_len8), .mode(cfg_parity), .data(tx_data), .start(tx_start),
    .busy(tx_busy), .txd(txd), .done(tx_done_w)
  );

  sio_irq_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_en),
    .len8(cfg_len8), .mode(cfg_parity), .route_err(cfg_err_route),
    .rxd(rxd), .rd(rx_read), .clr(err_clear),
    .data(rx_data), .full(rx_full),
    .err_par(err_parity), .err_frm(err_frame), .err_ovr(err_overrun),
    .irq_err(rx_err_w), .irq_done(rx_done_w)
  );

  assign req_w[REQ_TX]  = tx_done_w;
  assign req_w[REQ_RXD] = rx_done_w;
  assign req_w[REQ_RXE] = rx_err_w;

  sio_irq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_w), .ack(irq_ack), .code(irq_code)
  );

  assign irq_rx_err  = rx_err_w;
  assign irq_rx_done = rx_done_w;
  assign irq_tx_done = tx_done_w;

endmodule

// File: tb/sio_irq_uart_test.sv
module sio_irq_uart_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b1;
  logic tx_en = 1'b1, rx_en = 1'b1, cfg_len8 = 1'b1, cfg_err_route = 1'b1;
  logic [1:0] cfg_parity = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic tx_start = 1'b0, rxd = 1'b1, rx_read = 1'b0, err_clear = 1'b0, irq_ack = 1'b0;
  logic tx_busy, txd, rx_full, err_parity, err_frame, err_overrun;
  logic irq_rx_err, irq_rx_done, irq_tx_done;
  logic [7:0] rx_data;
  logic [1:0] irq_code;

  int checks = 0, errors = 0;
  int n_err = 0, n_done = 0, n_tx = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sio_irq_uart uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_len8(cfg_len8), .cfg_parity(cfg_parity), .cfg_err_route(cfg_err_route),
    .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_read(rx_read), .rx_data(rx_data), .rx_full(rx_full),
    .err_clear(err_clear), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .irq_rx_err(irq_rx_err), .irq_rx_done(irq_rx_done),
    .irq_tx_done(irq_tx_done), .irq_ack(irq_ack), .irq_code(irq_code)
  );

  always @(negedge clk) begin
    if (irq_rx_err)  n_err++;
    if (irq_rx_done) n_done++;
    if (irq_tx_done) n_tx++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ones_odd(input logic [7:0] d, input bit len8);
    int c = 0;
    for (int i = 0; i < 8; i++) if (i < 7 || len8) c += d[i];
    return c % 2 == 1;
  endfunction

  // bench-side parity bit per R4: even -> total ones even
  function automatic bit want_par(input logic [7:0] d, input bit len8, input logic [1:0] m);
    return (m == 2'd1) ? ones_odd(d, len8) : !ones_odd(d, len8);
  endfunction

  task automatic send_rx(input logic [7:0] d, input bit len8, input logic [1:0] m,
                         input bit badpar, input bit badstop);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < (len8 ? 8 : 7); i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (m == 2'd1 || m == 2'd2) begin
      rxd = want_par(d, len8, m) ^ badpar;
      repeat (16) @(negedge clk);
    end
    rxd = !badstop;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; @(negedge clk);
  endtask

  task automatic clean_up();
    rx_read = 1'b1; err_clear = 1'b1; @(negedge clk);
    rx_read = 1'b0; err_clear = 1'b0; @(negedge clk);
    for (int k = 0; k < 4; k++) if (irq_code != 2'd0) pulse_ack();
  endtask

  // ack in exactly the cycle the receive-done pulse is visible
  task automatic ack_on_rx_done();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (irq_rx_done) begin
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        break;
      end
    end
  endtask

  task automatic tx_frame(input logic [7:0] d, input bit len8, input logic [1:0] m,
                          input string req);
    logic [10:0] exp_f, got;
    int n, t0;
    bit found;
    n = (len8 ? 10 : 9) + ((m == 2'd1 || m == 2'd2) ? 1 : 0);
    exp_f = '1;
    exp_f[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < 7 || len8) exp_f[1 + i] = d[i];
    if (m == 2'd1 || m == 2'd2) exp_f[len8 ? 9 : 8] = want_par(d, len8, m);
    got = '1;
    t0 = n_tx;
    cfg_len8 = len8; cfg_parity = m; tx_data = d;
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    found = 1'b0;
    for (int k = 0; k < 40 && !found; k++) begin
      if (txd == 1'b0) found = 1'b1; else @(negedge clk);
    end
    chk(found, req, "tx start bit seen", found, 1);
    repeat (8) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (16) @(negedge clk);
      got[i] = txd;
    end
    chk(got == exp_f, req, "tx frame bits", got, exp_f);
    repeat (12) @(negedge clk);
    chk(n_tx - t0 == 1, "R2", "tx done pulses", n_tx - t0, 1);
    chk(txd == 1'b1 && !tx_busy, "R1", "idle high after frame", txd, 1);
  endtask

  // data, len8, parity, bad parity, bad stop, route, exp err pulse, exp parity flag, exp frame flag
  localparam logic [16:0] VEC [8] = '{
    {8'hA5, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hF0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h81, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h42, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hFF, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hEB, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=expired expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(txd == 1'b1, "R10", "txd", txd, 1);
    chk(!tx_busy && !rx_full, "R10", "busy/full", {tx_busy, rx_full}, 0);
    chk({err_parity, err_frame, err_overrun} == 3'b000, "R10", "flags",
        {err_parity, err_frame, err_overrun}, 0);
    chk(irq_code == 2'd0, "R10", "irq_code", irq_code, 0);
    chk(n_err + n_done + n_tx == 0, "R10", "no pulses", n_err + n_done + n_tx, 0);

    // table walk: receive patterns, parity modes, errors and routing (R3 R4 R5 R6)
    foreach (VEC[v]) begin
      logic [7:0] d, exp_d;
      int e0, d0;
      d = VEC[v][16:9];
      cfg_len8 = VEC[v][8]; cfg_parity = VEC[v][7:6]; cfg_err_route = VEC[v][3];
      exp_d = VEC[v][8] ? d : {1'b0, d[6:0]};
      e0 = n_err; d0 = n_done;
      send_rx(d, VEC[v][8], VEC[v][7:6], VEC[v][5], VEC[v][4]);
      chk(rx_data == exp_d, "R3", $sformatf("vec %0d rx_data", v), rx_data, exp_d);
      chk(rx_full, "R3", $sformatf("vec %0d rx_full", v), rx_full, 1);
      chk(n_err - e0 == int'(VEC[v][2]), "R6", $sformatf("vec %0d err pulses", v),
          n_err - e0, VEC[v][2]);
      chk(n_done - d0 == int'(!VEC[v][2]), "R6", $sformatf("vec %0d done pulses", v),
          n_done - d0, !VEC[v][2]);
      chk(err_parity == VEC[v][1], "R4", $sformatf("vec %0d parity flag", v),
          err_parity, VEC[v][1]);
      chk(err_frame == VEC[v][0], "R5", $sformatf("vec %0d frame flag", v),
          err_frame, VEC[v][0]);
      chk(irq_code == (VEC[v][2] ? 2'd3 : 2'd2), "R8", $sformatf("vec %0d code", v),
          irq_code, VEC[v][2] ? 3 : 2);
      clean_up();
      chk(!rx_full && !err_parity && !err_frame, "R5", "clear strobes",
          {rx_full, err_parity, err_frame}, 0);
    end

    // transmit frames R1 R2
    cfg_err_route = 1'b1;
    tx_frame(8'hC3, 1'b1, 2'd1, "R1");
    tx_frame(8'h2D, 1'b0, 2'd2, "R1");
    tx_frame(8'h96, 1'b1, 2'd0, "R1");
    chk(irq_code == 2'd1, "R8", "tx done pending", irq_code, 1);
    clean_up();

    // overrun R5
    cfg_len8 = 1'b1; cfg_parity = 2'd0;
    send_rx(8'h11, 1'b1, 2'd0, 1'b0, 1'b0);
    begin
      int e0;
      e0 = n_err;
      send_rx(8'h22, 1'b1, 2'd0, 1'b0, 1'b0);
      chk(err_overrun, "R5", "overrun flag", err_overrun, 1);
      chk(n_err - e0 == 1, "R6", "overrun error pulse", n_err - e0, 1);
      chk(rx_data == 8'h22, "R3", "overrun data", rx_data, 8'h22);
    end
    // priority R8: rx err + rx done + tx done pending
    tx_frame(8'h5F, 1'b1, 2'd0, "R1");
    chk(irq_code == 2'd3, "R8", "top code err", irq_code, 3);
    pulse_ack();
    chk(irq_code == 2'd2, "R8", "after ack rx done", irq_code, 2);
    pulse_ack();
    chk(irq_code == 2'd1, "R8", "after ack tx done", irq_code, 1);
    pulse_ack();
    chk(irq_code == 2'd0, "R9", "all retired", irq_code, 0);
    clean_up();

    // receiver disabled R7
    begin
      int e0, d0;
      e0 = n_err; d0 = n_done;
      rx_en = 1'b0;
      send_rx(8'h77, 1'b1, 2'd0, 1'b0, 1'b1);
      chk(n_err == e0 && n_done == d0, "R7", "no rx pulses", n_err + n_done - e0 - d0, 0);
      chk(!rx_full && irq_code == 2'd0, "R7", "no load", {rx_full, irq_code}, 0);
      chk(!err_frame, "R7", "no flag", err_frame, 0);
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
    end

    // same-cycle ack and receive-done R9
    tx_frame(8'h0F, 1'b1, 2'd0, "R1");
    chk(irq_code == 2'd1, "R9", "tx pending before collision", irq_code, 1);
    fork
      send_rx(8'h3A, 1'b1, 2'd0, 1'b0, 1'b0);
      ack_on_rx_done();
    join
    chk(irq_code == 2'd2, "R9", "ack retires tx, rx latched", irq_code, 2);
    rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
    fork
      send_rx(8'h3B, 1'b1, 2'd0, 1'b0, 1'b0);
      ack_on_rx_done();
    join
    chk(irq_code == 2'd2, "R9", "set wins over own ack", irq_code, 2);
    chk(!err_overrun, "R5", "read before next avoids overrun", err_overrun, 0);
    pulse_ack();
    chk(irq_code == 2'd0, "R9", "final ack", irq_code, 0);

    finished = 1'b1;
    finish_run();
  end
endmodule